// File: doc/BRIEF.md
# SPI FIFO Flag and Request Generator

This block sits beside the transmit and receive FIFOs of a serial peripheral interface controller. It takes the occupancy count of each FIFO, a strobe for each word written into the receive FIFO, and a busy indication from the shift engine. From these it builds an eight-bit status word. Six of the bits follow the FIFO levels directly. The other two are sticky event bits that stay set until software clears them.

The status word drives one interrupt line through per-bit enables. It also drives three DMA request lines. The first asks for transmit data when the transmit level is low. The second asks for receive service when the receive level is above its threshold. The third is a tail request. It lets a DMA engine collect the words left below the receive threshold once the shifter has gone idle.

All thresholds and enables arrive as plain inputs from a configuration register elsewhere. The FIFO storage and the shift engine sit outside this block.

Top module: `spi_fifo_flags`

## Requirements
- R1: The status word has a fixed bit layout. Bit 0 is transmit empty, bit 1 is transmit level request, bit 2 is transmit full, bit 3 is receive not-empty, bit 4 is receive level request, bit 5 is receive full, bit 6 is receive overflow and bit 7 is transfer done.
- R2: Bit 0 is set exactly when the transmit count is 0, and bit 2 is set exactly when the transmit count equals DEPTH. Both follow the count in the same cycle.
- R3: Bit 1 is set exactly when the transmit count is less than or equal to the transmit threshold.
- R4: Bit 3 is set when the receive count is nonzero, and bit 5 is set when the receive count equals DEPTH. Bit 4 is set when the receive count is strictly greater than the receive threshold.
- R5: A receive push while the receive count equals DEPTH sets bit 6 from the next clock edge on. Bit 6 stays set until it is cleared.
- R6: Bit 7 is set one edge after the condition "transmit count is 0 and shifter idle" goes from false to true. It is not set again while that condition merely persists.
- R7: A clear strobe with a 1 in bit 6 or bit 7 of its data clears that sticky bit at the next edge. A 0 in that position leaves the bit alone. A new set event in the same cycle wins over the clear. Ones written to bits 0 to 5 change nothing.
- R8: The interrupt output is the OR over all eight status bits, each ANDed with its own enable bit. Enable bit i belongs to status bit i.
- R9: The transmit DMA request equals bit 1 when its enable is set, and is 0 otherwise. The receive DMA request equals bit 4 when its enable is set, and is 0 otherwise.
- R10: The tail DMA request is high only when all of these hold: its enable is set, the shifter is idle, the receive count is nonzero, the receive count does not exceed the receive threshold, and the receive count is at least the tail length. A tail length of 0 counts as 1. The tail request and the receive DMA request are never high together.
- R11: Synchronous reset clears both sticky bits. A completion condition that is already present when reset releases does not set bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | CW | Words held in the transmit FIFO |
| rx_count | input | CW | Words held in the receive FIFO |
| rx_push | input | 1 | A word is written into the receive FIFO this cycle |
| shift_busy | input | 1 | Shift engine is moving a word |
| tx_thresh | input | CW | Transmit level threshold |
| rx_thresh | input | CW | Receive level threshold |
| tail_len | input | CW | Minimum leftover words for a tail request |
| irq_en | input | 8 | Per-status-bit interrupt enables |
| dma_tx_en | input | 1 | Enable for the transmit DMA request |
| dma_rx_en | input | 1 | Enable for the receive DMA request |
| dma_tail_en | input | 1 | Enable for the tail DMA request |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | 8 | Ones select the status bits to clear |
| status | output | 8 | Status word |
| irq | output | 1 | Masked interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tail_req | output | 1 | Receive tail DMA request |

## Verification
The bench puts each FIFO count exactly on its threshold and one word past it. A design that used the wrong comparison at the boundary would raise or drop a level request one word early. It holds the completion condition steady after a clear. A design that used the level of that condition instead of its rising edge would set bit 7 again at once, so software could never clear it. The bench also pushes and clears in the same cycle, which exposes a design where the clear wins and an overflow is lost. It writes ones to the live bits, which a design that let clears reach them would get wrong. Finally, it moves the receive count across the threshold and the tail length with the shifter idle and then busy. A design with the tail comparisons wrong would raise the tail request together with the receive request, or raise it while the shifter is still running.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int NUM_FLAGS   = 8;
    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_LVL   = 1;
    localparam int ST_TX_FULL  = 2;
    localparam int ST_RX_RDY   = 3;
    localparam int ST_RX_LVL   = 4;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_RX_OVF   = 6;
    localparam int ST_DONE     = 7;

    // Flags that follow the FIFO levels directly
    typedef struct packed {
        logic tx_empty;
        logic tx_lvl;
        logic tx_full;
        logic rx_rdy;
        logic rx_lvl;
        logic rx_full;
    } live_flags_t;

    function automatic logic [NUM_FLAGS-1:0] pack_status(
        input live_flags_t lf,
        input logic        ovf,
        input logic        done
    );
        logic [NUM_FLAGS-1:0] s;
        s              = '0;
        s[ST_TX_EMPTY] = lf.tx_empty;
        s[ST_TX_LVL]   = lf.tx_lvl;
        s[ST_TX_FULL]  = lf.tx_full;
        s[ST_RX_RDY]   = lf.rx_rdy;
        s[ST_RX_LVL]   = lf.rx_lvl;
        s[ST_RX_FULL]  = lf.rx_full;
        s[ST_RX_OVF]   = ovf;
        s[ST_DONE]     = done;
        return s;
    endfunction

endpackage

// File: rtl/spi_level_cmp.sv
module spi_level_cmp
    import spi_flag_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] rx_thresh,
    output live_flags_t   live
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    always_comb begin
        live.tx_empty = (tx_count == '0);
        live.tx_lvl   = (tx_count <= tx_thresh);
        live.tx_full  = (tx_count == FULL_LVL);
        live.rx_rdy   = (rx_count != '0);
        live.rx_lvl   = (rx_count > rx_thresh);
        live.rx_full  = (rx_count == FULL_LVL);
    end

    // A FIFO that is empty cannot also be full
    always_comb begin
        AST_TX_EMPTY_FULL: assert (!(live.tx_empty && live.tx_full)); // R2
    end
endmodule

// File: rtl/spi_sticky_flags.sv
module spi_sticky_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_push,
    input  logic       rx_full,
    input  logic       tx_empty,
    input  logic       shift_busy,
    input  logic       clr_we,
    input  logic [1:0] clr_bits,   // [0] overflow, [1] done
    output logic       ovf,
    output logic       done
);
    logic idle_now;
    logic idle_q;
    logic ovf_set;
    logic done_set;

    assign idle_now = tx_empty && !shift_busy;
    assign ovf_set  = rx_push && rx_full;
    assign done_set = idle_now && !idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf    <= 1'b0;
            done   <= 1'b0;
            idle_q <= 1'b1;
        end else begin
            idle_q <= idle_now;
            if (ovf_set)
                ovf <= 1'b1;
            else if (clr_we && clr_bits[0])
                ovf <= 1'b0;
            if (done_set)
                done <= 1'b1;
            else if (clr_we && clr_bits[1])
                done <= 1'b0;
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full) |=> ovf); // R5
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(clr_we && clr_bits[0])) |=> ovf); // R5
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits[1] && !(tx_empty && !shift_busy)) |=> !done); // R7
endmodule

// File: rtl/spi_req_gen.sv
module spi_req_gen
    import spi_flag_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] status,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic                 dma_tx_en,
    input  logic                 dma_rx_en,
    input  logic                 dma_tail_en,
    input  logic                 shift_busy,
    input  logic [CW-1:0]        rx_count,
    input  logic [CW-1:0]        rx_thresh,
    input  logic [CW-1:0]        tail_len,
    output logic                 irq,
    output logic                 dma_tx_req,
    output logic                 dma_rx_req,
    output logic                 dma_tail_req
);
    logic [CW-1:0] tail_min;

    assign tail_min = (tail_len == '0) ? CW'(1) : tail_len;

    always_comb begin
        irq          = |(status & irq_en);
        dma_tx_req   = dma_tx_en && status[ST_TX_LVL];
        dma_rx_req   = dma_rx_en && status[ST_RX_LVL];
        dma_tail_req = dma_tail_en && !shift_busy
                       && (rx_count != '0)
                       && (rx_count <= rx_thresh)
                       && (rx_count >= tail_min);
    end

    AST_TAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dma_rx_req && dma_tail_req)); // R10
    AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (rst)
        dma_tail_req |-> (!shift_busy && status[ST_RX_RDY])); // R10
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
    import spi_flag_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        tx_count,
    input  logic [CW-1:0]        rx_count,
    input  logic                 rx_push,
    input  logic                 shift_busy,
    input  logic [CW-1:0]        tx_thresh,
    input  logic [CW-1:0]        rx_thresh,
    input  logic [CW-1:0]        tail_len,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic                 dma_tx_en,
    input  logic                 dma_rx_en,
    input  logic                 dma_tail_en,
    input  logic                 clr_we,
    input  logic [NUM_FLAGS-1:0] clr_data,
    output logic [NUM_FLAGS-1:0] status,
    output logic                 irq,
    output logic                 dma_tx_req,
    output logic                 dma_rx_req,
    output logic                 dma_tail_req
);
    live_flags_t live;
    logic        ovf;
    logic        done;

    spi_level_cmp #(.DEPTH(DEPTH), .CW(CW)) u_lvl (
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .tx_thresh (tx_thresh),
        .rx_thresh (rx_thresh),
        .live      (live)
    );

    spi_sticky_flags u_sticky (
        .clk        (clk),
        .rst        (rst),
        .rx_push    (rx_push),
        .rx_full    (live.rx_full),
        .tx_empty   (live.tx_empty),
        .shift_busy (shift_busy),
        .clr_we     (clr_we),
        .clr_bits   ({clr_data[ST_DONE], clr_data[ST_RX_OVF]}),
        .ovf        (ovf),
        .done       (done)
    );

    assign status = pack_status(live, ovf, done);

    spi_req_gen #(.CW(CW)) u_req (
        .clk          (clk),
        .rst          (rst),
        .status       (status),
        .irq_en       (irq_en),
        .dma_tx_en    (dma_tx_en),
        .dma_rx_en    (dma_rx_en),
        .dma_tail_en  (dma_tail_en),
        .shift_busy   (shift_busy),
        .rx_count     (rx_count),
        .rx_thresh    (rx_thresh),
        .tail_len     (tail_len),
        .irq          (irq),
        .dma_tx_req   (dma_tx_req),
        .dma_rx_req   (dma_rx_req),
        .dma_tail_req (dma_tail_req)
    );

    AST_RST_CLEAN: assert property (@(posedge clk)
        rst |=> (status[ST_RX_OVF] == 1'b0 && status[ST_DONE] == 1'b0)); // R11
endmodule

// File: tb/spi_fifo_flags_bench.sv
`timescale 1ns/1ps
module spi_fifo_flags_bench;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] tx_count, rx_count, tx_thresh, rx_thresh, tail_len;
    logic          rx_push, shift_busy;
    logic [7:0]    irq_en, clr_data;
    logic          dma_tx_en, dma_rx_en, dma_tail_en, clr_we;
    logic [7:0]    status;
    logic          irq, dma_tx_req, dma_rx_req, dma_tail_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    spi_fifo_flags #(.DEPTH(DEPTH)) u_spi_fifo_flags (
        .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
        .rx_push(rx_push), .shift_busy(shift_busy), .tx_thresh(tx_thresh),
        .rx_thresh(rx_thresh), .tail_len(tail_len), .irq_en(irq_en),
        .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en), .dma_tail_en(dma_tail_en),
        .clr_we(clr_we), .clr_data(clr_data), .status(status), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .dma_tail_req(dma_tail_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one edge; inputs change 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; tx_count = '0; rx_count = '0; rx_push = 1'b0; shift_busy = 1'b0;
        tx_thresh = 7'd4; rx_thresh = 7'd4; tail_len = '0; irq_en = '0;
        dma_tx_en = 1'b0; dma_rx_en = 1'b0; dma_tail_en = 1'b0;
        clr_we = 1'b0; clr_data = '0;
        step(); step(); step();
        rst = 1'b0;
        step(); step();
        // Idle condition held across reset release: bit 7 must stay clear
        chk("R11 status after reset", status, 8'h03);
        chk("R11 irq after reset", irq, 1'b0);
    endtask

    task automatic t_tx_levels();
        shift_busy = 1'b1;
        tx_count = 7'd64; settle();
        chk("R2 tx full", status, 8'h04);
        tx_count = 7'd4; settle();
        chk("R3 tx at threshold", status, 8'h02);
        tx_count = 7'd5; settle();
        chk("R3 tx above threshold", status, 8'h00);
        step();
    endtask

    task automatic t_rx_levels();
        rx_count = 7'd1; settle();
        chk("R4 rx ready", status, 8'h08);
        rx_count = 7'd4; settle();
        chk("R4 rx at threshold", status, 8'h08);
        rx_count = 7'd5; settle();
        chk("R4 rx above threshold", status, 8'h18);
        rx_count = 7'd64; settle();
        chk("R1 rx full layout", status, 8'h38);
        step();
    endtask

    task automatic t_overflow();
        rx_count = 7'd63; rx_push = 1'b1; step();
        rx_push = 1'b0; settle();
        chk("R5 push not full", status[6], 1'b0);
        rx_count = 7'd64; rx_push = 1'b1; step();
        rx_push = 1'b0; rx_count = 7'd10; step(); step();
        chk("R5 overflow sticky", status[6], 1'b1);
        clr_we = 1'b1; clr_data = 8'hBF; step();
        clr_we = 1'b0; settle();
        chk("R7 zero keeps overflow", status[6], 1'b1);
        rx_count = 7'd64; rx_push = 1'b1; clr_we = 1'b1; clr_data = 8'h40; step();
        rx_push = 1'b0; clr_we = 1'b0; settle();
        chk("R7 set wins over clear", status[6], 1'b1);
        clr_we = 1'b1; clr_data = 8'h40; step();
        clr_we = 1'b0; settle();
        chk("R7 overflow cleared", status[6], 1'b0);
        rx_count = 7'd1;
    endtask

    task automatic t_done();
        shift_busy = 1'b1; tx_count = 7'd0; step(); step();
        chk("R6 busy blocks done", status[7], 1'b0);
        shift_busy = 1'b0; step();
        chk("R6 done set", status[7], 1'b1);
        clr_we = 1'b1; clr_data = 8'h80; step();
        clr_we = 1'b0; step(); step();
        chk("R6 no re-set while idle", status[7], 1'b0);
        // status now: tx empty + level, rx ready = 0x0B
        clr_we = 1'b1; clr_data = 8'h3F; step();
        clr_we = 1'b0; settle();
        chk("R7 live bits ignore clear", status, 8'h0B);
        shift_busy = 1'b1; tx_count = 7'd5; step();
    endtask

    task automatic t_irq();
        irq_en = 8'h08; settle();
        chk("R8 irq enabled bit", irq, 1'b1);
        irq_en = 8'hF7; settle();
        chk("R8 irq masked", irq, 1'b0);
        rx_count = 7'd64; rx_push = 1'b1; step();
        rx_push = 1'b0; rx_count = 7'd5; irq_en = 8'h40; settle();
        chk("R8 irq from overflow", irq, 1'b1);
        clr_we = 1'b1; clr_data = 8'h40; step();
        clr_we = 1'b0; settle();
        chk("R8 irq after clear", irq, 1'b0);
        irq_en = '0; rx_count = 7'd1;
    endtask

    task automatic t_dma();
        tx_count = 7'd2; settle();
        chk("R9 tx dma disabled", dma_tx_req, 1'b0);
        dma_tx_en = 1'b1; settle();
        chk("R9 tx dma enabled", dma_tx_req, 1'b1);
        tx_count = 7'd5; settle();
        chk("R9 tx dma above thresh", dma_tx_req, 1'b0);
        rx_count = 7'd5; settle();
        chk("R9 rx dma disabled", dma_rx_req, 1'b0);
        dma_rx_en = 1'b1; settle();
        chk("R9 rx dma enabled", dma_rx_req, 1'b1);
        rx_count = 7'd4; settle();
        chk("R9 rx dma at thresh", dma_rx_req, 1'b0);
        step();
    endtask

    task automatic t_tail();
        dma_tail_en = 1'b1; shift_busy = 1'b0; tx_count = 7'd5;
        rx_count = 7'd3; tail_len = 7'd2; settle();
        chk("R10 tail raised", dma_tail_req, 1'b1);
        tail_len = 7'd4; settle();
        chk("R10 tail below length", dma_tail_req, 1'b0);
        tail_len = 7'd3; settle();
        chk("R10 tail equal length", dma_tail_req, 1'b1);
        shift_busy = 1'b1; settle();
        chk("R10 tail busy", dma_tail_req, 1'b0);
        shift_busy = 1'b0; rx_count = 7'd0; tail_len = 7'd0; settle();
        chk("R10 tail empty fifo", dma_tail_req, 1'b0);
        rx_count = 7'd1; settle();
        chk("R10 tail zero length", dma_tail_req, 1'b1);
        rx_count = 7'd5; settle();
        chk("R10 tail above thresh", dma_tail_req, 1'b0);
        chk("R10 rx req instead", dma_rx_req, 1'b1);
        step();
    endtask

    initial begin
        t_reset();
        t_tx_levels();
        t_rx_levels();
        t_overflow();
        t_done();
        t_irq();
        t_dma();
        t_tail();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule